// File: doc/BRIEF.md
# Masked Priority Interrupt Resolver

This block sits between a set of interrupt request lines and a processor. Each clock it samples eight level-sensitive request lines into a request register. It removes the lines that a per-line mask register blocks. Of the lines that remain, the lowest-numbered one has the highest priority. The block raises an interrupt output when that winning line outranks every level that is already in service. Line 0 has the highest priority and line 7 the lowest.

An external acknowledge sequencer drives two strobes. The first strobe moves the current winner into the in-service register, clears that line's request bit and starts the service state. The last strobe ends the sequence. In automatic mode the last strobe also releases the in-service bit it granted. In manual mode an in-service bit stays set until an end-of-interrupt command clears it. That command is either non-specific, which releases the highest-priority in-service bit, or specific, which releases the level carried with the command. A read selector brings out the request, in-service and mask registers.

A small state machine controls the acknowledge sequence. It has two states:
- `ST_IDLE`: no sequence is open, and the interrupt output may be raised.
- `ST_SERVICE`: a grant has been made and the block waits for the last strobe. The interrupt output is held low and the granted level is presented.

It has two transitions. T_GRANT goes from `ST_IDLE` to `ST_SERVICE` when the first strobe arrives while the interrupt is pending. T_DONE goes from `ST_SERVICE` to `ST_IDLE` when the last strobe arrives.

Top module: `intr_resolver`

## Requirements
- R1: A request bit is set at the clock edge after its line is seen high, and it clears at the edge after the line is seen low, because the lines are level-sensitive.
- R2: A request whose mask bit is 1 never wins and never raises `int_out`. A mask write (`mask_wr`=1) loads `mask_data` at the next edge.
- R3: Masking a higher-priority line does not stop a lower-priority unmasked line from raising `int_out` or from being granted.
- R4: When `ack_first` is high in `ST_IDLE` while `int_out` is high, the lowest-numbered unmasked request is granted at that edge. Its in-service bit sets, its request bit reads 0 for one cycle, `vec_valid` goes to 1 and `vec_level` shows the granted line number.
- R5: With `auto_eoi`=1, an `ack_last` strobe in `ST_SERVICE` clears the in-service bit granted for that sequence at the same edge.
- R6: With `auto_eoi`=0, an in-service bit stays set after `ack_last`. A non-specific end-of-interrupt command (`eoi_cmd`=1, `eoi_specific`=0) clears only the lowest-numbered set in-service bit.
- R7: A specific end-of-interrupt command (`eoi_cmd`=1, `eoi_specific`=1) clears in-service bit `eoi_level` and no other bit. If that bit is already 0, nothing changes.
- R8: `int_out` is 1 only in `ST_IDLE`, and only when the lowest-numbered unmasked request has a lower number than every set in-service bit. It is 0 throughout `ST_SERVICE` and is evaluated again in the cycle after T_DONE.
- R9: After reset the request, in-service and mask registers read 0, `int_out` and `vec_valid` are 0, and the state is `ST_IDLE`. `rd_data` shows the request register for `rd_sel`=0, the in-service register for 1, the mask register for 2, and zero for 3.
- R10: `ack_first` has no effect when `int_out` is 0 or when the state is `ST_SERVICE`, and `ack_last` has no effect in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_LINES | Level-sensitive request lines |
| mask_wr | input | 1 | Load the mask register |
| mask_data | input | N_LINES | New mask value, where 1 blocks a line |
| auto_eoi | input | 1 | Release the in-service bit automatically on the last strobe |
| ack_first | input | 1 | First acknowledge strobe, which makes the grant |
| ack_last | input | 1 | Last acknowledge strobe, which ends the sequence |
| eoi_cmd | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 selects a specific command, 0 a non-specific one |
| eoi_level | input | LVL_W | Level that a specific command clears |
| rd_sel | input | 2 | Read-back select |
| rd_data | output | N_LINES | Selected register value |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | A grant is open (`ST_SERVICE`) |
| vec_level | output | LVL_W | Line number of the open grant |

## Verification
The bench drives a single line, sets of simultaneous lines, fully masked and partly masked sets, and requests that arrive below, at and above a level already in service. Together these separate a correct priority order from a reversed one, and masking applied after the request register from masking applied to the lines themselves. Grants are closed in automatic mode and with both kinds of end-of-interrupt command, including a specific command aimed at a bit that is already clear. This shows whether the right single in-service bit is released. Strobes that arrive at the wrong time show whether the state machine ignores them.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;

    localparam logic [1:0] RD_REQ  = 2'd0;
    localparam logic [1:0] RD_ISR  = 2'd1;
    localparam logic [1:0] RD_MASK = 2'd2;
endpackage

// File: rtl/prio_pick.sv
// Fixed-priority pick: the lowest set index wins.
module prio_pick #(
    parameter int N_LINES = 8,
    parameter int LVL_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] bits,
    output logic               found,
    output logic [LVL_W-1:0]   idx,
    output logic [N_LINES-1:0] onehot
);
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found  = 1'b1;
                idx    = LVL_W'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ack_seq_fsm.sv
// Controls the acknowledge sequence: IDLE -> SERVICE on grant, back on the last strobe.
module ack_seq_fsm
    import intr_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_first,
    input  logic             ack_last,
    input  logic             pending,
    input  logic [LVL_W-1:0] win_idx,
    output svc_state_e       state,
    output logic             grant,
    output logic             finish,
    output logic             int_out,
    output logic             vec_valid,
    output logic [LVL_W-1:0] held_idx
);
    svc_state_e state_nxt;

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (ack_first && pending) state_nxt = ST_SERVICE; // T_GRANT
            ST_SERVICE: if (ack_last)             state_nxt = ST_IDLE;    // T_DONE
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            held_idx <= '0;
        end else begin
            state <= state_nxt;
            if (grant) held_idx <= win_idx;
        end
    end

    // Outputs
    always_comb begin
        grant     = 1'b0;
        finish    = 1'b0;
        int_out   = 1'b0;
        vec_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                int_out = pending;
                grant   = ack_first && pending;
            end
            ST_SERVICE: begin
                vec_valid = 1'b1;
                finish    = ack_last;
            end
            default: ;
        endcase
    end

    AST_QUIET_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE) |-> !int_out); // R8
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && ack_last) |=> (state == ST_IDLE && !vec_valid)); // R10
    AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVICE && !ack_last) |=> $stable(held_idx)); // R10
endmodule

// File: rtl/intr_resolver.sv
module intr_resolver
    import intr_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int LVL_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               mask_wr,
    input  logic [N_LINES-1:0] mask_data,
    input  logic               auto_eoi,
    input  logic               ack_first,
    input  logic               ack_last,
    input  logic               eoi_cmd,
    input  logic               eoi_specific,
    input  logic [LVL_W-1:0]   eoi_level,
    input  logic [1:0]         rd_sel,
    output logic [N_LINES-1:0] rd_data,
    output logic               int_out,
    output logic               vec_valid,
    output logic [LVL_W-1:0]   vec_level
);
    localparam logic [N_LINES-1:0] ONE = N_LINES'(1);

    logic [N_LINES-1:0] irr, isr, imr;
    logic [N_LINES-1:0] eligible, req_oh, isr_oh;
    logic [N_LINES-1:0] grant_oh, eoi_clr, auto_clr;
    logic               req_found, isr_found, pending;
    logic [LVL_W-1:0]   req_idx, isr_idx, held_idx;
    logic               grant, finish;
    svc_state_e         state;

    assign eligible = irr & ~imr;

    prio_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_req_pick (
        .bits(eligible), .found(req_found), .idx(req_idx), .onehot(req_oh)
    );
    prio_pick #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_isr_pick (
        .bits(isr), .found(isr_found), .idx(isr_idx), .onehot(isr_oh)
    );

    assign pending = req_found && (!isr_found || (req_idx < isr_idx));

    ack_seq_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack_first(ack_first), .ack_last(ack_last),
        .pending(pending), .win_idx(req_idx), .state(state), .grant(grant),
        .finish(finish), .int_out(int_out), .vec_valid(vec_valid),
        .held_idx(held_idx)
    );
    assign vec_level = held_idx;

    assign grant_oh = grant ? req_oh : '0;
    assign eoi_clr  = !eoi_cmd     ? '0 :
                      eoi_specific ? (ONE << eoi_level) : isr_oh;
    assign auto_clr = (finish && auto_eoi) ? (ONE << held_idx) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
            imr <= '0;
        end else begin
            irr <= irq_in & ~grant_oh;
            isr <= (isr & ~(eoi_clr | auto_clr)) | grant_oh;
            if (mask_wr) imr <= mask_data;
        end
    end

    always_comb begin
        unique case (rd_sel)
            RD_REQ:  rd_data = irr;
            RD_ISR:  rd_data = isr;
            RD_MASK: rd_data = imr;
            default: rd_data = '0;
        endcase
    end

    AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !eoi_cmd) |=> isr[$past(req_idx)]); // R4
    AST_GRANT_CLEARS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !irr[$past(req_idx)]); // R4
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&imr) |-> !int_out); // R2
    AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && auto_eoi) |=> !isr[$past(held_idx)]); // R5
    AST_SPECIFIC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && eoi_specific && !grant) |=> !isr[$past(eoi_level)]); // R7
    AST_ISR_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !eoi_cmd) |=> ($countones(isr) == $past($countones(isr)) + 1)); // R4
endmodule

// File: tb/tb_intr_resolver.sv
`timescale 1ns/1ps
module tb_intr_resolver;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0, mask_data = '0;
    logic         mask_wr = 0, auto_eoi = 0, ack_first = 0, ack_last = 0;
    logic         eoi_cmd = 0, eoi_specific = 0;
    logic [2:0]   eoi_level = '0;
    logic [1:0]   rd_sel = '0;
    logic [N-1:0] rd_data;
    logic         int_out, vec_valid;
    logic [2:0]   vec_level;

    intr_resolver #(.N_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr(mask_wr),
        .mask_data(mask_data), .auto_eoi(auto_eoi), .ack_first(ack_first),
        .ack_last(ack_last), .eoi_cmd(eoi_cmd), .eoi_specific(eoi_specific),
        .eoi_level(eoi_level), .rd_sel(rd_sel), .rd_data(rd_data),
        .int_out(int_out), .vec_valid(vec_valid), .vec_level(vec_level)
    );

    always #2 clk = ~clk; // 250 MHz

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R9";
    bit    finished = 0;

    // Behavioural reference model
    bit [N-1:0] m_irr = '0, m_isr = '0, m_imr = '0;
    bit         m_busy = 0;
    int         m_held = 0;

    function automatic int lowest(bit [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    function automatic bit m_pend();
        int w = lowest(m_irr & ~m_imr);
        return (w < N) && (w < lowest(m_isr));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_imr = '0; m_busy = 0; m_held = 0;
        end else begin
            int w;
            bit gr, fin;
            bit [N-1:0] nisr;
            w    = lowest(m_irr & ~m_imr);
            gr   = !m_busy && ack_first && m_pend();
            fin  = m_busy && ack_last;
            nisr = m_isr;
            if (eoi_cmd) begin
                if (eoi_specific) nisr[eoi_level] = 1'b0;
                else if (lowest(m_isr) < N) nisr[lowest(m_isr)] = 1'b0;
            end
            if (fin && auto_eoi) nisr[m_held] = 1'b0;
            if (gr) nisr[w] = 1'b1;
            m_irr = irq_in;
            if (gr) m_irr[w] = 1'b0;
            m_isr = nisr;
            if (mask_wr) m_imr = mask_data;
            if (gr) begin m_busy = 1; m_held = w; end
            else if (fin) m_busy = 0;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit [N-1:0] e;
            e = (rd_sel == 2'd0) ? m_irr : (rd_sel == 2'd1) ? m_isr :
                (rd_sel == 2'd2) ? m_imr : '0;
            chk(int_out == m_pend() && !m_busy ? 1'b1 : (int_out == 1'b0 && !(m_pend() && !m_busy)),
                cur_req, "int_out", int_out, m_pend() && !m_busy);
            chk(rd_data == e, cur_req, "rd_data", rd_data, e);
            chk(vec_valid == m_busy, cur_req, "vec_valid", vec_valid, m_busy);
            if (m_busy) chk(vec_level == m_held[2:0], cur_req, "vec_level", vec_level, m_held);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_rd(logic [1:0] sel, logic [N-1:0] exp, string req);
        rd_sel = sel;
        #0.5;
        chk(rd_data == exp, req, $sformatf("rd_sel=%0d", sel), rd_data, exp);
    endtask

    task automatic exp_int(bit exp, string req);
        #0.5;
        chk(int_out == exp, req, "int_out", int_out, exp);
    endtask

    task automatic pulse_ack_first();
        ack_first = 1; tick(); ack_first = 0;
    endtask

    task automatic pulse_ack_last();
        ack_last = 1; tick(); ack_last = 0;
    endtask

    task automatic write_mask(logic [N-1:0] v);
        mask_wr = 1; mask_data = v; tick(); mask_wr = 0;
    endtask

    task automatic send_eoi(bit spec, logic [2:0] lvl);
        eoi_cmd = 1; eoi_specific = spec; eoi_level = lvl; tick(); eoi_cmd = 0; eoi_specific = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R9: reset state
        cur_req = "R9";
        exp_rd(2'd0, 8'h00, "R9"); exp_rd(2'd1, 8'h00, "R9");
        exp_rd(2'd2, 8'h00, "R9"); exp_rd(2'd3, 8'h00, "R9");
        exp_int(0, "R9");
        chk(vec_valid == 0, "R9", "vec_valid", vec_valid, 0);

        // R1: level-sensitive request latch
        cur_req = "R1"; rd_sel = 0;
        irq_in = 8'h24; tick();
        exp_rd(2'd0, 8'h24, "R1"); exp_int(1, "R1");
        irq_in = 8'h00; tick();
        exp_rd(2'd0, 8'h00, "R1"); exp_int(0, "R1");

        // R2: all lines masked
        cur_req = "R2";
        write_mask(8'hFF);
        exp_rd(2'd2, 8'hFF, "R2");
        irq_in = 8'hFF; tick();
        exp_rd(2'd0, 8'hFF, "R2"); exp_int(0, "R2");

        // R10: ack_first while int_out is low
        cur_req = "R10";
        pulse_ack_first();
        exp_rd(2'd1, 8'h00, "R10");
        chk(vec_valid == 0, "R10", "vec_valid", vec_valid, 0);

        // R3: line 0 masked, line 1 still served
        cur_req = "R3";
        write_mask(8'h01);
        exp_int(1, "R3");
        cur_req = "R4";
        pulse_ack_first();
        chk(vec_valid == 1, "R4", "vec_valid", vec_valid, 1);
        chk(vec_level == 3'd1, "R4", "vec_level", vec_level, 1);
        exp_rd(2'd1, 8'h02, "R4"); exp_rd(2'd0, 8'hFD, "R4");
        cur_req = "R8";
        exp_int(0, "R8");
        tick();
        exp_rd(2'd0, 8'hFF, "R1");
        // R10: second ack_first during service is ignored
        cur_req = "R10";
        pulse_ack_first();
        exp_rd(2'd1, 8'h02, "R10");
        chk(vec_level == 3'd1, "R10", "vec_level", vec_level, 1);

        // R6: manual mode keeps in-service bit after last strobe
        cur_req = "R6";
        pulse_ack_last();
        chk(vec_valid == 0, "R6", "vec_valid", vec_valid, 0);
        exp_rd(2'd1, 8'h02, "R6");
        cur_req = "R8";
        exp_int(0, "R8");          // line 1 is in service, best eligible is 1
        write_mask(8'h00);
        exp_int(1, "R8");          // line 0 outranks line 1
        irq_in = 8'h20; tick();
        exp_int(0, "R8");          // line 5 below line 1
        irq_in = 8'h01; tick();
        exp_int(1, "R8");
        cur_req = "R4";
        pulse_ack_first();
        chk(vec_level == 3'd0, "R4", "vec_level", vec_level, 0);
        exp_rd(2'd1, 8'h03, "R4");
        pulse_ack_last();

        cur_req = "R6";
        send_eoi(0, 3'd0);
        exp_rd(2'd1, 8'h02, "R6");

        // R7: specific commands
        cur_req = "R7";
        pulse_ack_first(); pulse_ack_last();
        exp_rd(2'd1, 8'h03, "R7");
        send_eoi(1, 3'd1);
        exp_rd(2'd1, 8'h01, "R7");
        send_eoi(1, 3'd6);
        exp_rd(2'd1, 8'h01, "R7");
        send_eoi(0, 3'd0);
        exp_rd(2'd1, 8'h00, "R6");

        // R5: automatic release
        cur_req = "R5";
        auto_eoi = 1; irq_in = 8'h80; tick();
        exp_int(1, "R5");
        pulse_ack_first();
        exp_rd(2'd1, 8'h80, "R5");
        chk(vec_level == 3'd7, "R5", "vec_level", vec_level, 7);
        pulse_ack_last();
        exp_rd(2'd1, 8'h00, "R5");
        exp_int(1, "R8");
        irq_in = 8'h00; tick();

        // R10: ack_last in idle
        cur_req = "R10";
        pulse_ack_last();
        exp_rd(2'd1, 8'h00, "R10");
        chk(vec_valid == 0, "R10", "vec_valid", vec_valid, 0);
        tick(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule